// File: doc/BRIEF.md
# Dual Channel Timer Peripheral

Two independent 32-bit timer/counter channels sit behind a plain single-cycle register port. Each channel has a control word, a load register and a counter that can be read at any time. A channel counts up or down once per clock while it runs. It can be preset from its load register. When it wraps, it either reloads and keeps running (periodic use) or stops on its own (one-shot use). Every wrap raises a per-channel status flag. The flags that are unmasked combine into one registered interrupt line.

Each channel runs a three-state machine that is decoded from its control word. ST_IDLE means stopped and holding. ST_PRELOAD means the counter is forced to the load value. ST_RUN means counting. The transitions are:
- IDLE→PRELOAD and RUN→PRELOAD when the load bit is written 1.
- PRELOAD→RUN when the load bit is written 0 with the enable bit set.
- PRELOAD→IDLE when the load bit is written 0 with the enable bit clear.
- IDLE→RUN when the enable bit is written 1, or when enable-all is written in either channel.
- RUN→IDLE when the enable bit is written 0, or when a wrap happens with auto-reload off.

A control write takes effect on the clock that follows it.

Top module: `dtmr_top`

## Requirements
- R1: After reset every register reads 0, both channels are in ST_IDLE and `irq` is low.
- R2: Word address bit 2 picks the channel. Bits 1:0 pick the register: 0 is control, 1 is load (read/write), 2 is counter (read-only, writes ignored), 3 reads 0. `rd_data` shows the addressed register in the same cycle as a read request and is 0 otherwise. Control bits above bit 10 read 0.
- R3: While control bit 5 (load) is 1, the counter takes the load register value on every clock.
- R4: In ST_RUN the counter decrements each clock when control bit 1 is 1, and increments when bit 1 is 0.
- R5: A wrap is a down count from 0 or an up count from 0xFFFFFFFF. It sets status bit 8 whether or not bit 6 (interrupt enable) is set. With bit 4 (auto-reload) set, the counter takes the load value and the channel stays running.
- R6: On a wrap with bit 4 clear, the channel clears its enable bit 7 and the counter holds its value at the wrap.
- R7: With bit 7 clear and bit 5 clear, the counter holds its value.
- R8: A control write with bit 8 = 1 clears the status flag, and a write with bit 8 = 0 leaves it unchanged. A wrap in the same clock leaves the flag set.
- R9: `irq` is high one clock after any channel has both bit 8 and bit 6 set, and low one clock after no channel does.
- R10: A control write to either channel with bit 10 set sets bit 7 in both channels in that clock.
- R11: Bits 0, 2, 3, 9 and 10 are stored and read back, and they have no effect on counting.
- R12: A control write changes behaviour from the next clock on. The counter update in the write clock uses the old control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_en | input | 1 | Bus request valid this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Word address |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data (combinational) |
| irq | output | 1 | Combined interrupt, registered |

## Verification
A corrupted counter shows up on the next read of the counter word. A wrong state decode lets the counter drift while the load bit is set, or stall while running, so it is seen within one read. A lost or spurious status flag shows on `irq` one clock later when its interrupt enable is set, and on the next control read otherwise. Wrong wrap handling leaves an enable bit that does not match, or a counter that has not reloaded, on the first read after the terminal count.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
    localparam int CTRL_W = 11;
    // control bit positions used by the logic
    localparam int B_DOWN = 1;
    localparam int B_AUTO = 4;
    localparam int B_LOAD = 5;
    localparam int B_IEN  = 6;
    localparam int B_RUN  = 7;
    localparam int B_FLAG = 8;
    localparam int B_ALL  = 10;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_LOAD = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PRELOAD = 2'd1,
        ST_RUN     = 2'd2
    } ch_state_e;
endpackage

// File: rtl/dtmr_channel.sv
module dtmr_channel
    import dtmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              load_we,
    input  logic              en_all,
    input  logic [W-1:0]      wdata,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [W-1:0]      load_o,
    output logic [W-1:0]      cnt_o
);
    localparam logic [W-1:0] TOP_VAL = '1;

    logic [CTRL_W-1:0] ctrl_q, ctrl_n;
    logic [W-1:0]      load_q, cnt_q, cnt_n;
    ch_state_e         state_q, state_n;
    logic              wrap;

    // terminal count while running
    always_comb begin
        wrap = (state_q == ST_RUN) &&
               (ctrl_q[B_DOWN] ? (cnt_q == '0) : (cnt_q == TOP_VAL));
    end

    // next control word: bus write, enable-all, wrap side effects
    always_comb begin
        ctrl_n = ctrl_q;
        if (ctrl_we) begin
            ctrl_n         = wdata[CTRL_W-1:0];
            ctrl_n[B_FLAG] = ctrl_q[B_FLAG] & ~wdata[B_FLAG];
        end
        if (en_all) ctrl_n[B_RUN] = 1'b1;
        if (wrap) begin
            ctrl_n[B_FLAG] = 1'b1;
            if (!ctrl_q[B_AUTO]) ctrl_n[B_RUN] = 1'b0;
        end
    end

    // next state from the control word that will be in force
    always_comb begin
        if (ctrl_n[B_LOAD])     state_n = ST_PRELOAD;
        else if (ctrl_n[B_RUN]) state_n = ST_RUN;
        else                    state_n = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // counter action per state
    always_comb begin
        cnt_n = cnt_q;
        unique case (state_q)
            ST_IDLE:    cnt_n = cnt_q;
            ST_PRELOAD: cnt_n = load_q;
            ST_RUN: begin
                if (wrap)                cnt_n = ctrl_q[B_AUTO] ? load_q : cnt_q;
                else if (ctrl_q[B_DOWN]) cnt_n = cnt_q - 1'b1;
                else                     cnt_n = cnt_q + 1'b1;
            end
            default:    cnt_n = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            load_q <= '0;
            cnt_q  <= '0;
        end else begin
            ctrl_q <= ctrl_n;
            cnt_q  <= cnt_n;
            if (load_we) load_q <= wdata;
        end
    end

    assign ctrl_o = ctrl_q;
    assign load_o = load_q;
    assign cnt_o  = cnt_q;
endmodule

// File: rtl/dtmr_rdmux.sv
module dtmr_rdmux
    import dtmr_pkg::*;
#(
    parameter int NCH = 2,
    parameter int W   = 32,
    parameter int CHW = 1
) (
    input  logic                         rd_en,
    input  logic [CHW-1:0]               ch_idx,
    input  logic [1:0]                   sel,
    input  logic [NCH-1:0][CTRL_W-1:0]   ctrl_a,
    input  logic [NCH-1:0][W-1:0]        load_a,
    input  logic [NCH-1:0][W-1:0]        cnt_a,
    output logic [W-1:0]                 data
);
    always_comb begin
        data = '0;
        if (rd_en && (int'(ch_idx) < NCH)) begin
            case (sel)
                SEL_CTRL: data = {{(W-CTRL_W){1'b0}}, ctrl_a[ch_idx]};
                SEL_LOAD: data = load_a[ch_idx];
                SEL_CNT:  data = cnt_a[ch_idx];
                default:  data = '0;
            endcase
        end
    end
endmodule

// File: rtl/dtmr_top.sv
module dtmr_top
    import dtmr_pkg::*;
#(
    parameter  int NCH = 2,
    parameter  int W   = 32,
    localparam int CHW = $clog2(NCH),
    localparam int AW  = CHW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_en,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [W-1:0]  req_wdata,
    output logic [W-1:0]  rd_data,
    output logic          irq
);
    logic [CHW-1:0] ch_idx;
    logic [1:0]     sel;
    logic           wr_any, en_all;

    logic [NCH-1:0][CTRL_W-1:0] ch_ctrl;
    logic [NCH-1:0][W-1:0]      ch_load;
    logic [NCH-1:0][W-1:0]      ch_cnt;
    logic [NCH-1:0]             pend;

    assign ch_idx = req_addr[AW-1:2];
    assign sel    = req_addr[1:0];
    assign wr_any = req_en && req_wr;
    assign en_all = wr_any && (sel == SEL_CTRL) && req_wdata[B_ALL];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit;
        assign hit = wr_any && (ch_idx == CHW'(g));
        dtmr_channel #(.W(W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl_we (hit && (sel == SEL_CTRL)),
            .load_we (hit && (sel == SEL_LOAD)),
            .en_all  (en_all),
            .wdata   (req_wdata),
            .ctrl_o  (ch_ctrl[g]),
            .load_o  (ch_load[g]),
            .cnt_o   (ch_cnt[g])
        );
        assign pend[g] = ch_ctrl[g][B_FLAG] && ch_ctrl[g][B_IEN];
    end

    dtmr_rdmux #(.NCH(NCH), .W(W), .CHW(CHW)) u_rd (
        .rd_en  (req_en && !req_wr),
        .ch_idx (ch_idx),
        .sel    (sel),
        .ctrl_a (ch_ctrl),
        .load_a (ch_load),
        .cnt_a  (ch_cnt),
        .data   (rd_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |pend;
    end
endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk
    import dtmr_pkg::*;
#(
    parameter int NCH = 2,
    parameter int W   = 32,
    parameter int AW  = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_en,
    input logic                       req_wr,
    input logic [AW-1:0]              req_addr,
    input logic [W-1:0]               req_wdata,
    input logic [NCH-1:0][CTRL_W-1:0] ch_ctrl,
    input logic [NCH-1:0][W-1:0]      ch_load,
    input logic [NCH-1:0][W-1:0]      ch_cnt,
    input logic                       irq
);
    for (genvar g = 0; g < NCH; g++) begin : g_a
        // R3
        preload_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_ctrl[g][B_LOAD] |=> (ch_cnt[g] == $past(ch_load[g])));
        // R7
        hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_ctrl[g][B_RUN] && !ch_ctrl[g][B_LOAD]) |=> $stable(ch_cnt[g]));
        // R4
        down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_ctrl[g][B_RUN] && !ch_ctrl[g][B_LOAD] && ch_ctrl[g][B_DOWN] && (ch_cnt[g] != '0))
            |=> (ch_cnt[g] == $past(ch_cnt[g]) - 1'b1));
        // R8
        flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ch_ctrl[g][B_FLAG]) |-> $past(req_en && req_wr && (req_addr[1:0] == 2'd0) &&
                (int'(req_addr[AW-1:2]) == g) && req_wdata[B_FLAG]));
        // R9
        irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_ctrl[g][B_FLAG] && ch_ctrl[g][B_IEN]) |=> irq);
    end
endmodule

bind dtmr_top dtmr_chk #(.NCH(NCH), .W(W), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_en    (req_en),
    .req_wr    (req_wr),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ch_ctrl   (ch_ctrl),
    .ch_load   (ch_load),
    .ch_cnt    (ch_cnt),
    .irq       (irq)
);

// File: tb/dtmr_top_test.sv
`timescale 1ns/1ps
module dtmr_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_en = 1'b0, req_wr = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic        irq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [10:0] m_ctrl [2];
    logic [31:0] m_load [2];
    logic [31:0] m_cnt  [2];
    bit          m_irq;

    always #10 clk = ~clk;

    dtmr_top uut (
        .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mread(logic [2:0] a);
        case (a[1:0])
            2'd0:    return {21'b0, m_ctrl[a[2]]};
            2'd1:    return m_load[a[2]];
            2'd2:    return m_cnt[a[2]];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string lbl(logic [1:0] s);
        case (s)
            2'd0:    return "R5 R6 R8 R10 R11 R12 control";
            2'd1:    return "R2 load";
            2'd2:    return "R3 R4 R5 R6 R7 R12 counter";
            default: return "R2 unmapped";
        endcase
    endfunction

    task automatic mstep(bit w, logic [2:0] a, logic [31:0] d);
        logic [10:0] nc [2];
        logic [31:0] nn [2];
        logic [31:0] nl [2];
        bit ni = 0;
        for (int c = 0; c < 2; c++) begin
            bit run, roll;
            ni |= m_ctrl[c][8] & m_ctrl[c][6];
            run  = m_ctrl[c][7] && !m_ctrl[c][5];
            roll = run && (m_ctrl[c][1] ? (m_cnt[c] == 0) : (m_cnt[c] == 32'hFFFF_FFFF));
            nn[c] = m_cnt[c];
            if (m_ctrl[c][5])  nn[c] = m_load[c];
            else if (roll)     nn[c] = m_ctrl[c][4] ? m_load[c] : m_cnt[c];
            else if (run)      nn[c] = m_ctrl[c][1] ? m_cnt[c] - 1 : m_cnt[c] + 1;
            nc[c] = m_ctrl[c];
            nl[c] = m_load[c];
            if (w && a[1:0] == 0 && a[2] == c[0]) begin
                nc[c] = d[10:0];
                nc[c][8] = m_ctrl[c][8] & ~d[8];
            end
            if (w && a[1:0] == 0 && d[10]) nc[c][7] = 1'b1;
            if (roll) begin
                nc[c][8] = 1'b1;
                if (!m_ctrl[c][4]) nc[c][7] = 1'b0;
            end
            if (w && a[1:0] == 1 && a[2] == c[0]) nl[c] = d;
        end
        for (int c = 0; c < 2; c++) begin
            m_ctrl[c] = nc[c]; m_cnt[c] = nn[c]; m_load[c] = nl[c];
        end
        m_irq = ni;
    endtask

    // one bus cycle: drive at negedge, check before the edge, advance model
    task automatic cyc(bit en, bit wr, logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        req_en = en; req_wr = wr; req_addr = a; req_wdata = d;
        #1;
        chk("R9 irq", {31'b0, irq}, {31'b0, m_irq});
        if (en && !wr) chk(lbl(a[1:0]), rd_data, mread(a));
        mstep(en && wr, a, d);
    endtask

    task automatic rd(logic [2:0] a); cyc(1, 0, a, 32'h0); endtask
    task automatic wr(logic [2:0] a, logic [31:0] d); cyc(1, 1, a, d); endtask

    task automatic ack(logic [2:0] a);
        logic [31:0] v;
        v = mread(a);
        rd(a);
        wr(a, v);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < 2; c++) begin
            m_ctrl[c] = '0; m_load[c] = '0; m_cnt[c] = '0;
        end
        m_irq = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int a = 0; a < 8; a++) begin
            @(negedge clk);
            req_en = 1; req_wr = 0; req_addr = 3'(a);
            #1;
            chk("R1 reset read", rd_data, 32'h0);
        end
        chk("R1 reset irq", {31'b0, irq}, 32'h0);

        // periodic down count on channel 0, then acknowledge
        wr(3'd1, 32'd3);
        wr(3'd0, 32'h20);
        rd(3'd2);
        wr(3'd0, 32'h1D2);
        repeat (12) rd(3'd2);
        chk("R5 flag after periodic wrap", mread(3'd0) & 32'h100, 32'h100);
        ack(3'd0);
        rd(3'd0);
        wr(3'd0, 32'h0);

        // one-shot up count on channel 1
        wr(3'd5, 32'hFFFF_FFFC);
        wr(3'd4, 32'h20);
        wr(3'd4, 32'h80);
        repeat (8) rd(3'd6);
        rd(3'd4);
        chk("R6 one-shot stopped", mread(3'd4) & 32'h80, 32'h0);
        // R8: write 0 to flag keeps it
        wr(3'd4, 32'h0);
        rd(3'd4);
        wr(3'd4, 32'h100);
        rd(3'd4);

        // R10: enable-all from channel 0 starts both
        wr(3'd4, 32'h2);
        wr(3'd0, 32'h402);
        rd(3'd0); rd(3'd4); rd(3'd6); rd(3'd2);
        wr(3'd0, 32'h0); wr(3'd4, 32'h0);

        // R11: inert bits stored, counting unchanged; R2 counter write ignored
        wr(3'd1, 32'd40); wr(3'd0, 32'h20);
        wr(3'd0, 32'h28F);
        wr(3'd2, 32'hDEAD_BEEF);
        repeat (4) rd(3'd2);
        rd(3'd0); rd(3'd3); rd(3'd7);
        wr(3'd0, 32'h0);

        // constrained random mix
        for (int i = 0; i < 6000; i++) begin
            int r;
            logic [2:0] a;
            logic [31:0] d;
            r = int'($urandom % 100);
            a = 3'($urandom);
            if (r < 40) cyc(0, 0, a, 32'h0);
            else if (r < 70) rd(a);
            else if (r < 85) begin
                d = $urandom & 32'h7FF;
                if ($urandom % 4 != 0) d[5] = 1'b0;
                if ($urandom % 8 != 0) d[10] = 1'b0;
                wr({a[2], 2'b00}, d);
            end else if (r < 95) begin
                d = ($urandom % 2 == 0) ? ($urandom % 8) : (32'hFFFF_FFF8 + ($urandom % 8));
                wr({a[2], 2'b01}, d);
            end else
                wr({a[2], 1'b1, a[0]}, $urandom);
        end

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule